// File: doc/BRIEF.md
# Gaussian Illumination Estimation Convolver

The block works out a smoothed estimate of ambient light for one output point of a luminance image. It does this by convolving a square window of 8-bit fractional pixels with a fixed Gaussian kernel. A host drives it over a small register port with AXI4-Lite-style valid/ready channels. The host pushes pixels one at a time, and each completed row of KSIZE pixels enters the bottom of the window while the oldest row leaves at the top. The host then writes a start bit, polls a status word and reads back the 8-bit result. To scan a column, the host first fills the window with KSIZE rows. After that it adds one row and starts again for each next point down the column. At the top of every new column the host clears the window and fills it afresh.

The kernel coefficients are 16-bit signed values with 12 fraction bits. They are computed at build time from the kernel size and sigma, multiplied by 2^SCALE_SH so that small values keep their precision, and rounded. Because the kernel has eight-fold symmetry, only one octant of coefficients is kept in a ROM. A single multiplier walks all KSIZE*KSIZE taps while the window rotates past it. The sum is then divided by 2^(12+SCALE_SH), rounded to 8 fraction bits and clamped. KSIZE defaults to 31 with sigma 12, and both can be changed.

Top module: `illum_conv_engine`

## Requirements
- R1: After reset, reading register index 0 (status: bit0 busy, bit1 result valid) returns 0, reading register index 2 (result, bits[7:0]) returns 0, and the window holds all zero pixels, so a start without any pixel writes yields result 0.
- R2: Each write to register index 1 takes bits[7:0] as the next pixel of the row, left to right. On the KSIZE-th write, every window row moves up by one, the top row is discarded and the new row becomes the bottom row.
- R3: A write of bit0 = 1 (with bit1 = 0) to register index 0 computes result = clamp(round(S / 2^(12+SCALE_SH)), 0, 255), where S is the sum over all taps of pixel × coefficient. Pixels and results are unsigned with 8 fraction bits, and rounding adds half an LSB before truncating.
- R4: The coefficient for a tap at offset (dx, dy) from the window centre is round(2^(12+SCALE_SH) · g(dx,dy) / Σg), with g = exp(-(dx²+dy²)/(2·SIGMA²)), the sum taken over the whole window, and the value capped at 32767. It depends only on the unordered pair (|dx|, |dy|).
- R5: When the rounded value exceeds 255, the result is 255.
- R6: While busy, start, clear and pixel writes are accepted on the bus but have no effect on the window, the row fill or the computation.
- R7: Reading register index 2 clears the result-valid bit. A new start also clears it.
- R8: A write of bit1 = 1 to register index 0 while idle zeroes the window and restarts row filling. If bit0 is also set in that write, it does not start a computation.
- R9: b_valid stays high until b_ready is high. r_valid stays high with r_data unchanged until r_ready is high. Reads of register index 3 return 0.
- R10: Busy reads 1 right after a start. It falls within KSIZE*KSIZE+4 cycles, and result-valid rises in the same cycle that busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_aw_valid | input | 1 | Write address valid |
| s_aw_ready | output | 1 | Write address accepted |
| s_aw_addr | input | 2 | Write register index |
| s_w_valid | input | 1 | Write data valid |
| s_w_ready | output | 1 | Write data accepted |
| s_w_data | input | 8 | Write data |
| s_b_valid | output | 1 | Write response valid |
| s_b_ready | input | 1 | Write response accepted |
| s_ar_valid | input | 1 | Read address valid |
| s_ar_ready | output | 1 | Read address accepted |
| s_ar_addr | input | 2 | Read register index |
| s_r_valid | output | 1 | Read data valid |
| s_r_ready | input | 1 | Read data accepted |
| s_r_data | output | 8 | Read data |

## Verification
The handshake properties assume that the host keeps s_b_ready and s_r_ready as free inputs and presents a write only with its address and data valid together. The bench always raises s_aw_valid and s_w_valid in the same cycle and holds them until they are accepted. The busy-length bound assumes that nothing outside the block stalls the tap walk. The bench therefore only waits a fixed time after each start and never reads the result before that time has passed. It exercises the window with impulses at several positions, random fills, an all-maximum fill and writes made during a computation.

// File: rtl/conv_pkg.sv
package conv_pkg;
  localparam int PIX_W     = 8;
  localparam int COEF_W    = 16;
  localparam int COEF_FRAC = 12;
  localparam int REG_W     = 2;
  localparam int PROD_W    = PIX_W + 1 + COEF_W;

  typedef logic [PIX_W-1:0]         pix_t;
  typedef logic signed [COEF_W-1:0] coef_t;

  typedef enum logic [REG_W-1:0] {
    REG_CTRL   = 2'd0,
    REG_ROW    = 2'd1,
    REG_RESULT = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;

  // index into a one-octant triangle: larger offset selects the row
  function automatic int octant_index(int a, int b);
    int lo, hi;
    lo = (a < b) ? a : b;
    hi = (a < b) ? b : a;
    return (hi * (hi + 1)) / 2 + lo;
  endfunction
endpackage

// File: rtl/conv_coef_rom.sv
module conv_coef_rom
  import conv_pkg::*;
#(
  parameter int  KSIZE    = 31,
  parameter real SIGMA    = 12.0,
  parameter int  SCALE_SH = 7,
  localparam int HALF     = (KSIZE - 1) / 2,
  localparam int DEPTH    = (HALF + 1) * (HALF + 2) / 2,
  localparam int AW       = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  output coef_t         data
);
  coef_t rom [DEPTH];

  function automatic real bell(int dx, int dy);
    return $exp(-real'(dx * dx + dy * dy) / (2.0 * SIGMA * SIGMA));
  endfunction

  initial begin : fill_rom
    real total;
    real v;
    int  q;
    total = 0.0;
    for (int dy = -HALF; dy <= HALF; dy++)
      for (int dx = -HALF; dx <= HALF; dx++)
        total = total + bell(dx, dy);
    for (int b = 0; b <= HALF; b++)
      for (int a = 0; a <= b; a++) begin
        v = bell(a, b) / total * (2.0 ** (COEF_FRAC + SCALE_SH));
        q = $rtoi(v + 0.5);
        if (q > 32767) q = 32767;
        rom[octant_index(a, b)] = coef_t'(q);
      end
  end

  always_ff @(posedge clk) begin
    data <= rom[addr];
  end
endmodule

// File: rtl/conv_pixel_window.sv
module conv_pixel_window
  import conv_pkg::*;
#(
  parameter int  KSIZE = 31,
  localparam int TAPS  = KSIZE * KSIZE,
  localparam int CW    = $clog2(KSIZE)
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic push,
  input  pix_t push_pix,
  input  logic rotate,
  output pix_t tap
);
  pix_t          win    [TAPS];
  pix_t          rowbuf [KSIZE-1];
  logic [CW-1:0] fill;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      for (int i = 0; i < TAPS; i++) win[i] <= '0;
      for (int j = 0; j < KSIZE - 1; j++) rowbuf[j] <= '0;
      fill <= '0;
    end else if (rotate) begin
      for (int i = 0; i < TAPS - 1; i++) win[i] <= win[i+1];
      win[TAPS-1] <= win[0];
    end else if (push) begin
      for (int j = 0; j < KSIZE - 2; j++) rowbuf[j] <= rowbuf[j+1];
      rowbuf[KSIZE-2] <= push_pix;
      if (fill == CW'(KSIZE - 1)) begin
        fill <= '0;
        for (int i = 0; i < TAPS - KSIZE; i++) win[i] <= win[i+KSIZE];
        for (int j = 0; j < KSIZE - 1; j++) win[TAPS-KSIZE+j] <= rowbuf[j];
        win[TAPS-1] <= push_pix;
      end else begin
        fill <= fill + CW'(1);
      end
    end
  end

  assign tap = win[0];
endmodule

// File: rtl/conv_mac.sv
module conv_mac
  import conv_pkg::*;
#(
  parameter int ACC_W = 30,
  parameter int DROP  = 19
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  in_valid,
  input  logic  in_first,
  input  logic  in_last,
  input  pix_t  pix,
  input  coef_t coef,
  output logic  done,
  output pix_t  result
);
  localparam logic signed [ACC_W-1:0] HALF_LSB = ACC_W'(1) <<< (DROP - 1);
  localparam logic signed [ACC_W-1:0] TOP_VAL  = ACC_W'(255);

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  rnd;
  logic                     fin;

  assign prod = $signed({1'b0, pix}) * coef;
  assign rnd  = (acc + HALF_LSB) >>> DROP;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      fin    <= 1'b0;
      done   <= 1'b0;
      result <= '0;
    end else begin
      fin  <= in_valid && in_last;
      done <= fin;
      if (in_valid)
        acc <= (in_first ? '0 : acc) + ACC_W'(prod);
      if (fin) begin
        if (rnd[ACC_W-1])       result <= '0;
        else if (rnd > TOP_VAL) result <= 8'hFF;
        else                    result <= rnd[PIX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/illum_conv_engine.sv
module illum_conv_engine
  import conv_pkg::*;
#(
  parameter int  KSIZE    = 31,
  parameter real SIGMA    = 12.0,
  parameter int  SCALE_SH = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s_aw_valid,
  output logic             s_aw_ready,
  input  logic [REG_W-1:0] s_aw_addr,
  input  logic             s_w_valid,
  output logic             s_w_ready,
  input  logic [PIX_W-1:0] s_w_data,
  output logic             s_b_valid,
  input  logic             s_b_ready,
  input  logic             s_ar_valid,
  output logic             s_ar_ready,
  input  logic [REG_W-1:0] s_ar_addr,
  output logic             s_r_valid,
  input  logic             s_r_ready,
  output logic [PIX_W-1:0] s_r_data
);
  localparam int TAPS  = KSIZE * KSIZE;
  localparam int HALF  = (KSIZE - 1) / 2;
  localparam int DEPTH = (HALF + 1) * (HALF + 2) / 2;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(KSIZE);
  localparam int TW    = $clog2(TAPS);
  localparam int ACC_W = PROD_W + $clog2(TAPS);
  localparam int DROP  = COEF_FRAC + SCALE_SH;

  logic     wr_fire, rd_fire;
  reg_sel_e wsel, rsel;
  logic     start_req, clear_req, push_req, rd_result;
  logic     busy_q, valid_q, issue_q;
  logic [TW-1:0] t_q;
  logic [CW-1:0] r_q, c_q, dr, dc, lo, hi;
  logic [AW-1:0] rom_addr;
  pix_t  tap, pix_d, result;
  coef_t coef;
  logic  vld_d, first_d, last_d, mac_done;

  // register port decode
  assign wr_fire    = s_aw_valid && s_w_valid && !s_b_valid;
  assign s_aw_ready = wr_fire;
  assign s_w_ready  = wr_fire;
  assign rd_fire    = s_ar_valid && !s_r_valid;
  assign s_ar_ready = rd_fire;
  assign wsel       = reg_sel_e'(s_aw_addr);
  assign rsel       = reg_sel_e'(s_ar_addr);
  assign clear_req  = wr_fire && (wsel == REG_CTRL) && s_w_data[1] && !busy_q;
  assign start_req  = wr_fire && (wsel == REG_CTRL) && s_w_data[0] && !s_w_data[1] && !busy_q;
  assign push_req   = wr_fire && (wsel == REG_ROW) && !busy_q;
  assign rd_result  = rd_fire && (rsel == REG_RESULT);

  always_ff @(posedge clk) begin
    if (rst) begin
      s_b_valid <= 1'b0;
      s_r_valid <= 1'b0;
      s_r_data  <= '0;
    end else begin
      if (wr_fire)        s_b_valid <= 1'b1;
      else if (s_b_ready) s_b_valid <= 1'b0;
      if (rd_fire) begin
        s_r_valid <= 1'b1;
        case (rsel)
          REG_CTRL:   s_r_data <= {{(PIX_W-2){1'b0}}, valid_q, busy_q};
          REG_RESULT: s_r_data <= result;
          default:    s_r_data <= '0;
        endcase
      end else if (s_r_ready) begin
        s_r_valid <= 1'b0;
      end
    end
  end

  // tap walk sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
      issue_q <= 1'b0;
      t_q     <= '0;
      r_q     <= '0;
      c_q     <= '0;
    end else begin
      if (start_req) begin
        busy_q  <= 1'b1;
        issue_q <= 1'b1;
        t_q     <= '0;
        r_q     <= '0;
        c_q     <= '0;
      end else if (issue_q) begin
        t_q <= t_q + TW'(1);
        if (c_q == CW'(KSIZE - 1)) begin
          c_q <= '0;
          r_q <= r_q + CW'(1);
        end else begin
          c_q <= c_q + CW'(1);
        end
        if (t_q == TW'(TAPS - 1)) issue_q <= 1'b0;
      end
      if (mac_done) begin
        busy_q  <= 1'b0;
        valid_q <= 1'b1;
      end else if (start_req || rd_result) begin
        valid_q <= 1'b0;
      end
    end
  end

  // coefficient address from the folded offset
  always_comb begin
    dr = (r_q >= CW'(HALF)) ? r_q - CW'(HALF) : CW'(HALF) - r_q;
    dc = (c_q >= CW'(HALF)) ? c_q - CW'(HALF) : CW'(HALF) - c_q;
    lo = (dr < dc) ? dr : dc;
    hi = (dr < dc) ? dc : dr;
    rom_addr = AW'((int'(hi) * (int'(hi) + 1)) / 2 + int'(lo));
  end

  // align pixel with the registered ROM output
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_d   <= 1'b0;
      first_d <= 1'b0;
      last_d  <= 1'b0;
      pix_d   <= '0;
    end else begin
      vld_d   <= issue_q;
      first_d <= issue_q && (t_q == '0);
      last_d  <= issue_q && (t_q == TW'(TAPS - 1));
      pix_d   <= tap;
    end
  end

  conv_coef_rom #(.KSIZE(KSIZE), .SIGMA(SIGMA), .SCALE_SH(SCALE_SH)) rom_i (
    .clk  (clk),
    .addr (rom_addr),
    .data (coef)
  );

  conv_pixel_window #(.KSIZE(KSIZE)) win_i (
    .clk      (clk),
    .rst      (rst),
    .clear    (clear_req),
    .push     (push_req),
    .push_pix (s_w_data),
    .rotate   (issue_q),
    .tap      (tap)
  );

  conv_mac #(.ACC_W(ACC_W), .DROP(DROP)) mac_i (
    .clk      (clk),
    .rst      (rst),
    .in_valid (vld_d),
    .in_first (first_d),
    .in_last  (last_d),
    .pix      (pix_d),
    .coef     (coef),
    .done     (mac_done),
    .result   (result)
  );
endmodule

// File: rtl/illum_conv_checker.sv
module illum_conv_checker #(
  parameter int TAPS = 961
) (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       res_valid,
  input logic       b_valid,
  input logic       b_ready,
  input logic       r_valid,
  input logic       r_ready,
  input logic [7:0] r_data
);
  localparam int LIMIT = TAPS + 4;
  int unsigned busy_len;

  always_ff @(posedge clk) begin
    if (rst || !busy) busy_len <= 0;
    else              busy_len <= busy_len + 1;
  end

  assert_busy_bounded_R10: assert property (@(posedge clk) disable iff (rst)
    busy |-> (busy_len <= LIMIT));

  assert_valid_at_finish_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(res_valid) |-> $fell(busy));

  assert_read_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (r_valid && !r_ready) |=> (r_valid && $stable(r_data)));

  assert_write_resp_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (b_valid && !b_ready) |=> b_valid);
endmodule

bind illum_conv_engine illum_conv_checker #(.TAPS(KSIZE * KSIZE)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy_q),
  .res_valid (valid_q),
  .b_valid   (s_b_valid),
  .b_ready   (s_b_ready),
  .r_valid   (s_r_valid),
  .r_ready   (s_r_ready),
  .r_data    (s_r_data)
);

// File: tb/illum_conv_engine_tb_top.sv
`timescale 1ns/1ps
module illum_conv_engine_tb_top;
  localparam int  K     = 5;
  localparam real SIG   = 1.5;
  localparam int  SSH   = 3;
  localparam int  TAPS  = K * K;
  localparam int  H     = (K - 1) / 2;
  localparam int  DROP  = 12 + SSH;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic aw_valid = 0, w_valid = 0, b_ready = 1, ar_valid = 0, r_ready = 1;
  logic [1:0] aw_addr = 0, ar_addr = 0;
  logic [7:0] w_data = 0;
  logic aw_ready, w_ready, b_valid, ar_ready, r_valid;
  logic [7:0] r_data;

  always #2 clk = ~clk;

  illum_conv_engine #(.KSIZE(K), .SIGMA(SIG), .SCALE_SH(SSH)) dut_i (
    .clk(clk), .rst(rst),
    .s_aw_valid(aw_valid), .s_aw_ready(aw_ready), .s_aw_addr(aw_addr),
    .s_w_valid(w_valid), .s_w_ready(w_ready), .s_w_data(w_data),
    .s_b_valid(b_valid), .s_b_ready(b_ready),
    .s_ar_valid(ar_valid), .s_ar_ready(ar_ready), .s_ar_addr(ar_addr),
    .s_r_valid(r_valid), .s_r_ready(r_ready), .s_r_data(r_data)
  );

  typedef struct { logic [7:0] data; string tag; } sb_item_t;
  sb_item_t sb_q [$];
  int n_checks = 0;
  int n_fail   = 0;

  // reference model
  int bwin [TAPS];
  int mrow [K-1];
  int mfill = 0;
  int m_result = 0;
  bit m_busy = 0;

  function automatic real bell(int dx, int dy);
    return $exp(-real'(dx * dx + dy * dy) / (2.0 * SIG * SIG));
  endfunction

  function automatic int coef_of(int dx, int dy);
    real total = 0.0;
    int q;
    for (int y = -H; y <= H; y++)
      for (int x = -H; x <= H; x++)
        total += bell(x, y);
    q = $rtoi(bell(dx, dy) / total * (2.0 ** DROP) + 0.5);
    return (q > 32767) ? 32767 : q;
  endfunction

  function automatic int model_conv();
    longint acc = 0;
    longint q;
    for (int r = 0; r < K; r++)
      for (int c = 0; c < K; c++)
        acc += longint'(bwin[r*K+c]) * coef_of(r - H, c - H);
    q = (acc + (longint'(1) << (DROP - 1))) >>> DROP;
    if (q < 0) q = 0;
    if (q > 255) q = 255;
    return int'(q);
  endfunction

  function automatic void model_clear();
    for (int i = 0; i < TAPS; i++) bwin[i] = 0;
    for (int j = 0; j < K - 1; j++) mrow[j] = 0;
    mfill = 0;
  endfunction

  function automatic void model_push(int p);
    if (mfill == K - 1) begin
      for (int i = 0; i < TAPS - K; i++) bwin[i] = bwin[i+K];
      for (int j = 0; j < K - 1; j++) bwin[TAPS-K+j] = mrow[j];
      bwin[TAPS-1] = p;
      mfill = 0;
    end else begin
      mrow[mfill] = p;
      mfill++;
    end
  endfunction

  task automatic check(input int act, input int exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: compares every read data beat with the scoreboard
  always @(negedge clk) begin
    if (!rst && r_valid && r_ready) begin
      if (sb_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R9 unexpected read actual=%0d expected=none", r_data);
      end else begin
        sb_item_t it;
        it = sb_q.pop_front();
        n_checks++;
        if (r_data !== it.data) begin
          n_fail++;
          $display("FAIL %s actual=%0d expected=%0d", it.tag, r_data, it.data);
        end
      end
    end
  end

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    aw_valid = 1; w_valid = 1; aw_addr = a; w_data = d;
    #0.5;
    while (!aw_ready) begin @(negedge clk); #0.5; end
    @(posedge clk); #0.5;
    aw_valid = 0; w_valid = 0;
  endtask

  task automatic bus_read(input logic [1:0] a, input int exp, input string tag);
    sb_q.push_back('{data: exp[7:0], tag: tag});
    @(negedge clk);
    ar_valid = 1; ar_addr = a;
    #0.5;
    while (!ar_ready) begin @(negedge clk); #0.5; end
    @(posedge clk); #0.5;
    ar_valid = 0;
    @(posedge clk); #0.5;
  endtask

  task automatic push_pixel(input int p);
    bus_write(2'd1, p[7:0]);
    if (!m_busy) model_push(p);
  endtask

  task automatic push_row(input int base, input int step);
    for (int c = 0; c < K; c++) push_pixel((base + step * c) & 255);
  endtask

  task automatic clear_win();
    bus_write(2'd0, 8'h02);
    if (!m_busy) model_clear();
  endtask

  task automatic start_conv(input string tag);
    bus_write(2'd0, 8'h01);
    if (!m_busy) begin
      m_result = model_conv();
      m_busy = 1;
    end
    bus_read(2'd0, 1, tag);
  endtask

  task automatic finish_conv(input string tag);
    repeat (TAPS + 6) @(negedge clk);
    m_busy = 0;
    bus_read(2'd0, 2, "R10 status after finish");
    bus_read(2'd2, m_result, tag);
    bus_read(2'd0, 0, "R7 valid cleared by result read");
  endtask

  task automatic impulse(input int r0, input int c0, input string tag);
    clear_win();
    for (int r = 0; r < K; r++)
      for (int c = 0; c < K; c++)
        push_pixel((r == r0 && c == c0) ? 255 : 0);
    start_conv("R10 busy after start");
    finish_conv(tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL R10 watchdog actual=hang expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin : stim
    logic [7:0] held;
    model_clear();
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset state
    bus_read(2'd0, 0, "R1 status after reset");
    bus_read(2'd2, 0, "R1 result after reset");
    start_conv("R10 busy after first start");
    finish_conv("R1 zero window gives zero");
    // R4 impulses at symmetric and asymmetric positions
    impulse(H, H, "R4 impulse centre");
    impulse(0, 0, "R4 impulse corner");
    impulse(1, 3, "R4 impulse off-axis");
    impulse(3, 1, "R4 impulse mirrored");
    impulse(4, 2, "R4 impulse edge");
    // R3 general patterns
    clear_win();
    for (int r = 0; r < K; r++) push_row(17 * r + 3, 11);
    start_conv("R10 busy gradient");
    finish_conv("R3 gradient window");
    clear_win();
    for (int i = 0; i < TAPS; i++) push_pixel($urandom_range(0, 255));
    start_conv("R10 busy random");
    finish_conv("R3 random window");
    // R2 slide down one row
    push_row(200, 7);
    start_conv("R10 busy slide");
    finish_conv("R2 slide one row");
    push_row(5, 40);
    start_conv("R10 busy slide 2");
    finish_conv("R2 slide second row");
    // R5 all maximum
    clear_win();
    for (int i = 0; i < TAPS; i++) push_pixel(255);
    start_conv("R10 busy full");
    finish_conv("R5 all-max clamped");
    // R6 writes during busy are ignored
    clear_win();
    for (int r = 0; r < K; r++) push_row(30 * r, 9);
    start_conv("R10 busy before ignored writes");
    bus_write(2'd0, 8'h01);
    push_pixel(99); push_pixel(98); push_pixel(97);
    clear_win();
    finish_conv("R6 result unaffected by busy writes");
    start_conv("R10 busy restart");
    finish_conv("R6 window unaffected by busy writes");
    // R8 clear, partial row then clear, both-bits write
    push_pixel(50); push_pixel(60);
    clear_win();
    push_row(100, 3);
    bus_write(2'd0, 8'h03);
    model_clear();
    bus_read(2'd0, 0, "R8 clear with start does not start");
    start_conv("R10 busy after clear");
    finish_conv("R8 cleared window zero");
    // R7 start clears valid, R9 unmapped read
    for (int r = 0; r < K; r++) push_row(r * 50 + 1, 1);
    start_conv("R10 busy valid test");
    repeat (TAPS + 6) @(negedge clk);
    m_busy = 0;
    bus_read(2'd0, 2, "R7 valid set before read");
    start_conv("R7 start clears valid");
    finish_conv("R3 ramp window");
    bus_read(2'd3, 0, "R9 unmapped read zero");
    // R9 read data held while not accepted
    r_ready = 0;
    sb_q.push_back('{data: m_result[7:0], tag: "R9 held read released"});
    @(negedge clk); ar_valid = 1; ar_addr = 2'd2;
    #0.5;
    while (!ar_ready) begin @(negedge clk); #0.5; end
    @(posedge clk); #0.5; ar_valid = 0;
    @(negedge clk); held = r_data;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(int'(r_valid), 1, "R9 r_valid held");
      check(int'(r_data), int'(held), "R9 r_data stable");
    end
    r_ready = 1;
    @(posedge clk); #0.5;
    // R9 write response held
    b_ready = 0;
    bus_write(2'd0, 8'h00);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(int'(b_valid), 1, "R9 b_valid held");
    end
    b_ready = 1;
    repeat (3) @(negedge clk);
    check(int'(b_valid), 0, "R9 b_valid released");
    check(sb_q.size(), 0, "R9 scoreboard drained");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule